// File: doc/BRIEF.md
# Buffered Step Seek Controller

This block sits on the drive side of a step-and-direction disk interface. It turns host step pulses into a target cylinder for a head positioner. It samples the asynchronous step and direction lines through a synchronizer. On the first accepted leading edge it drops the seek-complete status and asks the positioner to move right away. Further pulses that arrive while the heads are already moving are folded into the target, so one train becomes one buffered seek rather than a series of single-track moves.

A train ends when no new pulse arrives within a programmable quiet window. Only then is the target marked final, and the positioner's on-track acknowledge returns the block to idle. Inward counts saturate at the top cylinder. An outward count that would pass cylinder 0 becomes a recalibrate, and a recalibrate is also issued by itself after reset. Status outputs are driven only while the drive is selected. A seek already under way runs to completion after deselection, so the host can overlap seeks on several drives.

Top module: `seek_step_ctrl`

## Requirements
- R1: After reset, `seek_done_o` is 0 and the positioner request is active with `move_recal_o`=1 and `move_final_o`=1 until `on_track_i` is seen; after that the block is idle at cylinder 0 with `track0_o`=1.
- R2: A leading edge on `step_i` that is accepted in idle makes `seek_done_o` fall exactly at the third rising clock edge after `step_i` rises (two synchronizer stages, then the edge register). It is still 1 after the second edge.
- R3: Each accepted step moves the target by one cylinder: +1 when `dir_in_i`=1 (inward), −1 when `dir_in_i`=0 (outward). Direction is sampled through the same synchronizer depth as the step.
- R4: While a train is being collected, `move_req_o`=1, `move_final_o`=0, and `move_cyl_o` follows the running target after every accepted pulse.
- R5: A train closes after WINDOW_CYC cycles pass with no new accepted pulse. `move_final_o` then rises and `move_cyl_o` holds steady until the acknowledge.
- R6: Inward steps at cylinder MAX_CYL (default 1023) leave the target at MAX_CYL.
- R7: An outward step at cylinder 0 sets `move_recal_o`. The committed cylinder is 0 and `track0_o`=1 once the seek ends. An outward train that lands exactly on 0 does not recalibrate.
- R8: `seek_done_o` rises only in the cycle after `on_track_i` is sampled while `move_final_o`=1. `track0_o` is 1 only when the block is idle at cylinder 0.
- R9: `step_rate_ok_o` is set at the first pulse of a train. It is cleared if any later pulse of that train comes fewer than MIN_GAP_CYC cycles after the previous one, and it keeps its value until the next train.
- R10: While `drive_sel_i`=0, `seek_done_o`, `track0_o` and `step_rate_ok_o` are 0 and step pulses are ignored. A seek already started still completes and is reported once the drive is selected again.
- R11: Step pulses that arrive while the target is final (during a power-on or train settle) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_i | input | 1 | Step line, active high, asynchronous |
| dir_in_i | input | 1 | Direction, 1 = inward toward MAX_CYL, 0 = outward toward 0 |
| drive_sel_i | input | 1 | Drive selected qualifier |
| on_track_i | input | 1 | Positioner settled on the final target (one-cycle pulse) |
| move_req_o | output | 1 | Positioner move requested |
| move_final_o | output | 1 | Target is final; acknowledge awaited |
| move_recal_o | output | 1 | Move is a recalibrate to cylinder 0 |
| move_cyl_o | output | CYL_W | Target cylinder |
| seek_done_o | output | 1 | Seek complete status (gated by select) |
| track0_o | output | 1 | Heads on cylinder 0 (gated by select) |
| step_rate_ok_o | output | 1 | Last train respected the minimum step spacing (gated by select) |

## Verification
The fall of seek-complete is due at the third clock edge after the step line rises. The bench pins this down by sampling at the falling edge after the second rising edge and again after the third. The running target is due two to three edges after each pulse, so it is sampled in the low phase of the next pulse. The final flag and the committed cylinder are due WINDOW_CYC edges later. The bench waits for its modelled positioner to take the acknowledge and then reads the cylinder the positioner saw, rather than counting edges. Idle status is read two falling edges after the acknowledge, one edge later than it is due.

// File: rtl/seek_pkg.sv
package seek_pkg;
  typedef enum logic [1:0] {
    SK_IDLE   = 2'd0,
    SK_TRAIN  = 2'd1,
    SK_SETTLE = 2'd2
  } seek_st_e;
endpackage

// File: rtl/seek_step_sync.sv
module seek_step_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic dir_i,
  output logic rise_o,
  output logic dir_o
);
  logic [STAGES:0]   step_sh;
  logic [STAGES-1:0] dir_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_sh <= '0;
      dir_sh  <= '0;
    end else begin
      step_sh <= {step_sh[STAGES-1:0], step_i};
      dir_sh  <= {dir_sh[STAGES-2:0], dir_i};
    end
  end

  // leading edge seen after the synchronizer depth
  assign rise_o = step_sh[STAGES-1] & ~step_sh[STAGES];
  assign dir_o  = dir_sh[STAGES-1];
endmodule

// File: rtl/seek_target.sv
module seek_target #(
  parameter int CYL_W   = 10,
  parameter int MAX_CYL = 1023
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             dir_i,
  input  logic             commit_i,
  output logic [CYL_W-1:0] tgt_o,
  output logic             recal_o
);
  localparam logic [CYL_W-1:0] TOP = CYL_W'(MAX_CYL);

  logic [CYL_W-1:0] tgt_q, tgt_d;
  logic             recal_q, recal_d;

  always_comb begin
    tgt_d   = tgt_q;
    recal_d = recal_q;
    if (commit_i) begin
      recal_d = 1'b0;
      if (recal_q) tgt_d = '0;
    end else if (accept_i) begin
      if (dir_i) begin
        if (tgt_q != TOP) tgt_d = tgt_q + CYL_W'(1);
      end else if (tgt_q == '0) begin
        recal_d = 1'b1;
      end else begin
        tgt_d = tgt_q - CYL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= '0;
      recal_q <= 1'b1;
    end else begin
      tgt_q   <= tgt_d;
      recal_q <= recal_d;
    end
  end

  assign tgt_o   = tgt_q;
  assign recal_o = recal_q;

  assert_clamp_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && !commit_i && dir_i && tgt_q == TOP) |=> (tgt_o == TOP));

  assert_under_zero_recal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && !commit_i && !dir_i && tgt_q == '0) |=> (recal_o && tgt_o == '0));

  assert_step_moves_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && !commit_i && dir_i && tgt_q != TOP) |=> (tgt_o == $past(tgt_q) + CYL_W'(1)));
endmodule

// File: rtl/seek_window.sv
module seek_window #(
  parameter int WINDOW_CYC  = 40000,
  parameter int MIN_GAP_CYC = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  input  logic first_i,
  input  logic train_i,
  output logic close_o,
  output logic rate_ok_o
);
  localparam int CW = $clog2(WINDOW_CYC + 1);
  localparam logic [CW-1:0] LAST    = CW'(WINDOW_CYC - 1);
  localparam logic [CW-1:0] GAP_LIM = CW'(MIN_GAP_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rate_q, rate_d;

  always_comb begin
    cnt_d  = cnt_q;
    rate_d = rate_q;
    if (accept_i)                       cnt_d = '0;
    else if (train_i && cnt_q != LAST)  cnt_d = cnt_q + CW'(1);
    if (first_i)                        rate_d = 1'b1;
    else if (accept_i && cnt_q < GAP_LIM) rate_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rate_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      rate_q <= rate_d;
    end
  end

  assign close_o   = train_i && !accept_i && (cnt_q == LAST);
  assign rate_ok_o = rate_q;

  assert_first_sets_rate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    first_i |=> rate_ok_o);
endmodule

// File: rtl/seek_step_ctrl.sv
module seek_step_ctrl #(
  parameter int CYL_W       = 10,
  parameter int MAX_CYL     = 1023,
  parameter int SYNC_STAGES = 2,
  parameter int WINDOW_CYC  = 40000,
  parameter int MIN_GAP_CYC = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             dir_in_i,
  input  logic             drive_sel_i,
  input  logic             on_track_i,
  output logic             move_req_o,
  output logic             move_final_o,
  output logic             move_recal_o,
  output logic [CYL_W-1:0] move_cyl_o,
  output logic             seek_done_o,
  output logic             track0_o,
  output logic             step_rate_ok_o
);
  import seek_pkg::*;

  logic [1:0] rst_sh;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_int = rst_sh[1];

  logic rise, dir_s, accept, first, commit, close, rate_ok, recal;
  logic [CYL_W-1:0] tgt;
  seek_st_e st_q, st_d;

  seek_step_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int), .step_i(step_i), .dir_i(dir_in_i),
    .rise_o(rise), .dir_o(dir_s)
  );

  assign accept = rise && drive_sel_i && (st_q != SK_SETTLE);
  assign first  = accept && (st_q == SK_IDLE);
  assign commit = (st_q == SK_SETTLE) && on_track_i;

  seek_target #(.CYL_W(CYL_W), .MAX_CYL(MAX_CYL)) u_target (
    .clk(clk), .rst_n(rst_int), .accept_i(accept), .dir_i(dir_s),
    .commit_i(commit), .tgt_o(tgt), .recal_o(recal)
  );

  seek_window #(.WINDOW_CYC(WINDOW_CYC), .MIN_GAP_CYC(MIN_GAP_CYC)) u_window (
    .clk(clk), .rst_n(rst_int), .accept_i(accept), .first_i(first),
    .train_i(st_q == SK_TRAIN), .close_o(close), .rate_ok_o(rate_ok)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SK_IDLE:   if (accept)     st_d = SK_TRAIN;
      SK_TRAIN:  if (close)      st_d = SK_SETTLE;
      SK_SETTLE: if (on_track_i) st_d = SK_IDLE;
      default:                   st_d = SK_SETTLE;
    endcase
  end

  // reset lands in settle with a recalibrate pending: power-on recal
  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) st_q <= SK_SETTLE;
    else          st_q <= st_d;
  end

  assign move_req_o     = (st_q != SK_IDLE);
  assign move_final_o   = (st_q == SK_SETTLE);
  assign move_recal_o   = recal;
  assign move_cyl_o     = tgt;
  assign seek_done_o    = drive_sel_i && (st_q == SK_IDLE);
  assign track0_o       = drive_sel_i && (st_q == SK_IDLE) && (tgt == '0);
  assign step_rate_ok_o = drive_sel_i && rate_ok;

  assert_step_drops_done_R2: assert property (@(posedge clk) disable iff (!rst_int)
    (st_q == SK_IDLE && rise && drive_sel_i) |=> !move_final_o && move_req_o && !seek_done_o);

  assert_done_needs_ack_R8: assert property (@(posedge clk) disable iff (!rst_int)
    $rose(st_q == SK_IDLE) |-> $past(on_track_i) && $past(move_final_o));

  assert_final_target_steady_R11: assert property (@(posedge clk) disable iff (!rst_int)
    (move_final_o && $past(move_final_o)) |-> $stable(move_cyl_o) && $stable(move_recal_o));

  assert_deselect_quiet_R10: assert property (@(posedge clk) disable iff (!rst_int)
    !drive_sel_i |-> !seek_done_o && !track0_o && !step_rate_ok_o);

  assert_idle_track0_R8: assert property (@(posedge clk) disable iff (!rst_int)
    track0_o |-> (move_cyl_o == '0) && !move_req_o);
endmodule

// File: tb/seek_step_ctrl_bench.sv
module seek_step_ctrl_bench;
  localparam int CW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0, dir_in = 1'b0, sel = 1'b1, on_track = 1'b0;
  logic move_req, move_final, move_recal, seek_done, track0, rate_ok;
  logic [CW-1:0] move_cyl;

  int checks = 0, errors = 0, commits = 0, seen = 0, cyl = 0;
  int last_cyl = 0, last_recal = 0;
  bit hold_ack = 1'b0, ended = 1'b0;

  always #2.5 clk = ~clk;

  seek_step_ctrl #(.CYL_W(CW), .MAX_CYL(1023), .SYNC_STAGES(2),
                   .WINDOW_CYC(64), .MIN_GAP_CYC(8)) u_seek_step_ctrl (
    .clk(clk), .rst_n(rst_n), .step_i(step), .dir_in_i(dir_in),
    .drive_sel_i(sel), .on_track_i(on_track), .move_req_o(move_req),
    .move_final_o(move_final), .move_recal_o(move_recal), .move_cyl_o(move_cyl),
    .seek_done_o(seek_done), .track0_o(track0), .step_rate_ok_o(rate_ok)
  );

  // {dir, pulses, expected cylinder, expected recal}
  localparam int VEC [9][4] = '{
    '{1, 5, 5, 0}, '{1, 3, 8, 0}, '{0, 2, 6, 0}, '{0, 6, 0, 0},
    '{1, 1020, 1020, 0}, '{1, 10, 1023, 0}, '{0, 1000, 23, 0},
    '{0, 30, 0, 1}, '{1, 1, 1, 0}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // positioner model: acknowledges a final target 6 cycles after it appears
  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      on_track = 1'b0;
      if (!rst_n) dly = 0;
      else if (move_req && move_final && !hold_ack) begin
        if (dly == 5) begin
          on_track = 1'b1;
          last_cyl = int'(move_cyl);
          last_recal = int'(move_recal);
          commits++;
          dly = 0;
        end else dly++;
      end else dly = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    finish_run();
  end

  task automatic train(input bit d, input int n, input int hi, input int lo);
    dir_in = d;
    repeat (3) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      step = 1'b1; repeat (hi) @(negedge clk);
      step = 1'b0; repeat (lo) @(negedge clk);
    end
  endtask

  task automatic wait_commit(input string req);
    int t = 0;
    while (commits == seen && t < 5000) begin @(negedge clk); t++; end
    chk({req, " commit seen"}, int'(commits != seen), 1);
    seen = commits;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 power-on recalibrate
    chk("R1 seek_done in recal", int'(seek_done), 0);
    chk("R1 move_req in recal", int'(move_req), 1);
    chk("R1 recal flagged", int'(move_recal), 1);
    chk("R1 final in recal", int'(move_final), 1);
    wait_commit("R1");
    chk("R1 recal committed", last_recal, 1);
    chk("R1 track0 after recal", int'(track0), 1);
    chk("R1 seek_done after recal", int'(seek_done), 1);

    // table walk: R3 R6 R7 R8
    for (int v = 0; v < 9; v++) begin
      train(VEC[v][0][0], VEC[v][1], 4, 6);
      wait_commit("R3");
      chk("R3 R6 R7 committed cylinder", last_cyl, VEC[v][2]);
      chk("R7 recal flag", last_recal, VEC[v][3]);
      chk("R8 seek_done after ack", int'(seek_done), 1);
      chk("R8 track0", int'(track0), int'(VEC[v][2] == 0));
      chk("R9 rate ok at legal spacing", int'(rate_ok), 1);
    end
    cyl = 1;

    // R2 exact fall of seek_done
    dir_in = 1'b1; repeat (3) @(negedge clk);
    step = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R2 done still high at edge 2", int'(seek_done), 1);
    @(posedge clk); @(negedge clk);
    chk("R2 done low at edge 3", int'(seek_done), 0);
    chk("R4 final low in train", int'(move_final), 0);
    repeat (2) @(negedge clk); step = 1'b0;
    wait_commit("R2");
    cyl++;
    chk("R2 single step cylinder", last_cyl, cyl);

    // R4 running target, R5 window
    train(1'b1, 3, 4, 6);
    chk("R4 running target", int'(move_cyl), cyl + 3);
    chk("R4 move_req in train", int'(move_req), 1);
    train(1'b1, 1, 4, 6);
    repeat (30) @(negedge clk);
    chk("R5 still open inside window", int'(move_final), 0);
    wait_commit("R5");
    cyl += 4;
    chk("R5 committed after window", last_cyl, cyl);

    // R9 step rate
    train(1'b1, 3, 2, 2);
    wait_commit("R9");
    cyl += 3;
    chk("R9 fast train cylinder", last_cyl, cyl);
    chk("R9 rate flag cleared", int'(rate_ok), 0);
    train(1'b1, 1, 4, 6);
    wait_commit("R9");
    cyl += 1;
    chk("R9 rate flag restored", int'(rate_ok), 1);

    // R10 deselected: quiet status, steps ignored
    sel = 1'b0; @(negedge clk);
    chk("R10 done gated", int'(seek_done), 0);
    chk("R10 rate gated", int'(rate_ok), 0);
    train(1'b1, 5, 4, 6);
    repeat (100) @(negedge clk);
    chk("R10 no move while deselected", int'(move_req), 0);
    chk("R10 no commit while deselected", commits - seen, 0);
    sel = 1'b1; @(negedge clk);
    chk("R10 done when reselected", int'(seek_done), 1);
    train(1'b1, 1, 4, 6);
    wait_commit("R10");
    cyl += 1;
    chk("R10 ignored steps left target", last_cyl, cyl);

    // R10 overlapped seek completes while deselected
    train(1'b1, 3, 4, 6);
    sel = 1'b0;
    wait_commit("R10");
    cyl += 3;
    chk("R10 overlap cylinder", last_cyl, cyl);
    chk("R10 overlap done hidden", int'(seek_done), 0);
    sel = 1'b1; @(negedge clk);
    chk("R10 overlap done shown", int'(seek_done), 1);

    // R11 steps during settle ignored
    hold_ack = 1'b1;
    train(1'b1, 2, 4, 6);
    for (int t = 0; t < 200 && !move_final; t++) @(negedge clk);
    train(1'b1, 3, 4, 6);
    chk("R11 target held in settle", int'(move_cyl), cyl + 2);
    chk("R11 still final", int'(move_final), 1);
    hold_ack = 1'b0;
    wait_commit("R11");
    cyl += 2;
    chk("R11 committed cylinder", last_cyl, cyl);

    finish_run();
  end
endmodule